// File: doc/BRIEF.md
# Boot Memory Alias Controller

After reset, this block decides whether boot ROM or flash appears at the bottom of the address map. Once reset is released it waits a fixed settle time and then samples a boot-select pin. If the pin asks for the ROM boot loader, the block selects ROM at once. If it does not, the block fetches the flash reset-vector word through a request/valid handshake. A word that reads as fully erased means the flash is blank, and the block then selects ROM. The CPU is held in a boot-pending state until this decision is made.

The decision is kept in a single alias bit. Software reads this bit through a small register port. It can clear the bit by writing a one, and it can never set it. A registered address router uses the alias bit to steer accesses in the low window either to ROM or to flash. ROM also stays reachable at its own base address at all times.

Top module: `boot_remap_ctrl`

## Requirements
- R1: While `rst` is high, and for SETTLE_CYCLES+2 cycles after it falls, `cpu_hold` is 1. During reset, `remap`, `probe_req`, `reg_rdata`, `sel_rom` and `sel_flash` are all 0. Once `cpu_hold` falls, it stays 0 until the next reset.
- R2: The pin is sampled in the cycle after the settle count. If `boot_pin` equals BOOT_ROM_LEVEL (default 1) at that point, the alias bit becomes 1 and `cpu_hold` falls on the same edge. No flash probe is issued.
- R3: If the sampled pin does not select ROM, `probe_req` rises with `probe_addr` = 0x4. It stays high until the edge on which `probe_valid` is seen high.
- R4: On the edge that accepts `probe_valid`, the alias bit becomes 1 if `probe_data` is 0xFFFFFFFF and 0 for any other value. `probe_req` and `cpu_hold` both fall on that edge.
- R5: A read (`reg_sel`=1, `reg_wr`=0) at `reg_addr` 0x0F0 returns the alias bit in bit 0, with bits 31:1 zero. A read at any other offset returns 0. `reg_rdata` is valid one cycle after the request and is 0 in cycles with no read.
- R6: A write at 0x0F0 with bit 0 = 1 clears the alias bit. A write with bit 0 = 0, a write at another offset, and any write made while `cpu_hold` is 1 all leave the bit unchanged.
- R7: No register write can set the alias bit. Only the post-reset decision can set it.
- R8: One cycle after a request (`bus_req`=1), an address below WINDOW (0x10000) selects ROM (`sel_rom`) when the alias bit is 1 and flash (`sel_flash`) when it is 0. In both cases `dev_addr` equals the address.
- R9: An address in [ROM_BASE, ROM_BASE+ROM_SIZE) (0x01000000 to 0x0100FFFF) always selects ROM, with `dev_addr` = address − ROM_BASE. An address in [WINDOW, FLASH_SIZE) (up to 0x3FFFF) selects flash. Any other address, and any cycle with no request, selects nothing, with `dev_addr` = 0. At most one select is ever high.
- R10: `remap` always equals the current alias bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_pin | input | 1 | Boot-select pin level |
| probe_req | output | 1 | Flash reset-vector fetch request |
| probe_addr | output | AW | Flash word address being fetched |
| probe_valid | input | 1 | Flash fetch data valid |
| probe_data | input | DW | Flash fetch data |
| cpu_hold | output | 1 | CPU held while the boot decision is pending |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | OW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, one cycle after the read |
| bus_req | input | 1 | Address decode request |
| bus_addr | input | AW | Address to decode |
| sel_rom | output | 1 | Access routed to ROM |
| sel_flash | output | 1 | Access routed to flash |
| dev_addr | output | AW | Offset inside the selected device |
| remap | output | 1 | ROM aliased at address zero |

## Verification
The hardest case to reach is a clear-write that arrives while the decision is still pending. Such a write must lose to a blank-flash result that sets the alias bit a few cycles later. To reach it, the bench holds a write of all ones on the register port from the first cycle after reset. It keeps that write in place through the settle count and a slow flash reply, and releases it only on the cycle after `cpu_hold` drops. The bench also varies the flash reply latency from zero to several cycles. It uses an erased word, a word one bit short of erased, and an ordinary vector. This separates the probe path from the ROM-pin path, and it places the decoder checks under both alias states within the same run.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SAMPLE,
    ST_PROBE,
    ST_DONE
  } boot_st_e;
endpackage

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_remap_pkg::*;
#(
  parameter int             AW             = 32,
  parameter int             DW             = 32,
  parameter int             SETTLE_CYCLES  = 4,
  parameter logic           BOOT_ROM_LEVEL = 1'b1,
  parameter logic [AW-1:0]  RV_ADDR        = 'h4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_pin,
  input  logic          probe_valid,
  input  logic [DW-1:0] probe_data,
  output logic          probe_req,
  output logic [AW-1:0] probe_addr,
  output logic          cpu_hold,
  output logic          decide_valid,
  output logic          decide_alias
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  boot_st_e st;
  logic [CW-1:0] cnt;
  logic pin_rom;

  assign pin_rom = (boot_pin == BOOT_ROM_LEVEL);

  // decision event towards the alias register
  assign decide_valid = (st == ST_SAMPLE && pin_rom) || (st == ST_PROBE && probe_valid);
  assign decide_alias = (st == ST_SAMPLE) ? 1'b1 : (&probe_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      cpu_hold   <= 1'b1;
      probe_req  <= 1'b0;
      probe_addr <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          st  <= ST_SETTLE;
          cnt <= '0;
        end
        ST_SETTLE: begin
          if (cnt == CW'(SETTLE_CYCLES - 1)) st <= ST_SAMPLE;
          else cnt <= cnt + 1'b1;
        end
        ST_SAMPLE: begin
          if (pin_rom) begin
            cpu_hold <= 1'b0;
            st       <= ST_DONE;
          end else begin
            probe_req  <= 1'b1;
            probe_addr <= RV_ADDR;
            st         <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (probe_valid) begin
            probe_req  <= 1'b0;
            probe_addr <= '0;
            cpu_hold   <= 1'b0;
            st         <= ST_DONE;
          end
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    probe_req && !probe_valid |=> probe_req); // R3
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    probe_req && probe_valid |=> !probe_req && !cpu_hold); // R4
  AST_HOLD_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
    !cpu_hold |=> !cpu_hold); // R1
  AST_ROM_NO_PROBE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SAMPLE && pin_rom) |=> !probe_req && !cpu_hold); // R2
endmodule

// File: rtl/alias_flag_reg.sv
module alias_flag_reg #(
  parameter int            DW         = 32,
  parameter int            OW         = 12,
  parameter logic [OW-1:0] REG_OFFSET = 'h0F0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          decide_valid,
  input  logic          decide_alias,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [OW-1:0] reg_addr,
  input  logic          wdata_lsb,
  output logic          alias_q,
  output logic [DW-1:0] reg_rdata
);
  logic hit, wr_hit, rd_hit;

  assign hit    = reg_sel && (reg_addr == REG_OFFSET);
  assign wr_hit = hit && reg_wr;
  assign rd_hit = hit && !reg_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      alias_q <= 1'b0;
    end else if (decide_valid) begin
      alias_q <= decide_alias;
    end else if (wr_hit && wdata_lsb && !hold) begin
      alias_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_hit) reg_rdata <= '0;
    else                reg_rdata <= {{(DW-1){1'b0}}, alias_q};
  end

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(alias_q) |-> $past(decide_valid)); // R7
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wdata_lsb && !hold && !decide_valid) |=> !alias_q); // R6
  AST_W0_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!decide_valid && !(wr_hit && wdata_lsb)) |=> $stable(alias_q)); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DW-1:1] == '0); // R5
endmodule

// File: rtl/low_addr_router.sv
module low_addr_router #(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] WINDOW     = 'h0001_0000,
  parameter logic [AW-1:0] ROM_BASE   = 'h0100_0000,
  parameter logic [AW-1:0] ROM_SIZE   = 'h0001_0000,
  parameter logic [AW-1:0] FLASH_SIZE = 'h0004_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alias_on,
  input  logic          bus_req,
  input  logic [AW-1:0] bus_addr,
  output logic          sel_rom,
  output logic          sel_flash,
  output logic [AW-1:0] dev_addr
);
  localparam logic [AW-1:0] ROM_END = ROM_BASE + ROM_SIZE;

  logic in_low, in_rom, in_flash;

  assign in_low   = bus_addr < WINDOW;
  assign in_rom   = (bus_addr >= ROM_BASE) && (bus_addr < ROM_END);
  assign in_flash = bus_addr < FLASH_SIZE;

  always_ff @(posedge clk) begin
    if (rst || !bus_req) begin
      sel_rom   <= 1'b0;
      sel_flash <= 1'b0;
      dev_addr  <= '0;
    end else if (in_low) begin
      sel_rom   <= alias_on;
      sel_flash <= !alias_on;
      dev_addr  <= bus_addr;
    end else if (in_rom) begin
      sel_rom   <= 1'b1;
      sel_flash <= 1'b0;
      dev_addr  <= bus_addr - ROM_BASE;
    end else if (in_flash) begin
      sel_rom   <= 1'b0;
      sel_flash <= 1'b1;
      dev_addr  <= bus_addr;
    end else begin
      sel_rom   <= 1'b0;
      sel_flash <= 1'b0;
      dev_addr  <= '0;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !(sel_rom && sel_flash)); // R9
  AST_LOW_TO_ROM: assert property (@(posedge clk) disable iff (rst)
    (bus_req && in_low && alias_on) |=> sel_rom); // R8
  AST_LOW_TO_FLASH: assert property (@(posedge clk) disable iff (rst)
    (bus_req && in_low && !alias_on) |=> sel_flash); // R8
endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl #(
  parameter int             AW             = 32,
  parameter int             DW             = 32,
  parameter int             OW             = 12,
  parameter int             SETTLE_CYCLES  = 4,
  parameter logic           BOOT_ROM_LEVEL = 1'b1,
  parameter logic [AW-1:0]  RV_ADDR        = 'h4,
  parameter logic [OW-1:0]  REG_OFFSET     = 'h0F0,
  parameter logic [AW-1:0]  WINDOW         = 'h0001_0000,
  parameter logic [AW-1:0]  ROM_BASE       = 'h0100_0000,
  parameter logic [AW-1:0]  ROM_SIZE       = 'h0001_0000,
  parameter logic [AW-1:0]  FLASH_SIZE     = 'h0004_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_pin,
  output logic          probe_req,
  output logic [AW-1:0] probe_addr,
  input  logic          probe_valid,
  input  logic [DW-1:0] probe_data,
  output logic          cpu_hold,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [OW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          bus_req,
  input  logic [AW-1:0] bus_addr,
  output logic          sel_rom,
  output logic          sel_flash,
  output logic [AW-1:0] dev_addr,
  output logic          remap
);
  logic decide_valid, decide_alias, alias_q;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DW-1:1];
  assign remap = alias_q;

  boot_seq_fsm #(
    .AW(AW), .DW(DW), .SETTLE_CYCLES(SETTLE_CYCLES),
    .BOOT_ROM_LEVEL(BOOT_ROM_LEVEL), .RV_ADDR(RV_ADDR)
  ) u_seq (
    .clk(clk), .rst(rst), .boot_pin(boot_pin),
    .probe_valid(probe_valid), .probe_data(probe_data),
    .probe_req(probe_req), .probe_addr(probe_addr), .cpu_hold(cpu_hold),
    .decide_valid(decide_valid), .decide_alias(decide_alias)
  );

  alias_flag_reg #(
    .DW(DW), .OW(OW), .REG_OFFSET(REG_OFFSET)
  ) u_flag (
    .clk(clk), .rst(rst), .hold(cpu_hold),
    .decide_valid(decide_valid), .decide_alias(decide_alias),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wdata_lsb(reg_wdata[0]), .alias_q(alias_q), .reg_rdata(reg_rdata)
  );

  low_addr_router #(
    .AW(AW), .WINDOW(WINDOW), .ROM_BASE(ROM_BASE),
    .ROM_SIZE(ROM_SIZE), .FLASH_SIZE(FLASH_SIZE)
  ) u_route (
    .clk(clk), .rst(rst), .alias_on(alias_q),
    .bus_req(bus_req), .bus_addr(bus_addr),
    .sel_rom(sel_rom), .sel_flash(sel_flash), .dev_addr(dev_addr)
  );
endmodule

// File: tb/test_boot_remap_ctrl.sv
`timescale 1ns/1ps
module test_boot_remap_ctrl;
  localparam int SETTLE = 4;
  localparam logic [11:0] OFF = 12'h0F0;
  localparam logic [31:0] WIN = 32'h0001_0000;
  localparam logic [31:0] RBASE = 32'h0100_0000;
  localparam logic [31:0] RSIZE = 32'h0001_0000;
  localparam logic [31:0] FSIZE = 32'h0004_0000;

  logic clk = 0;
  logic rst = 1;
  logic boot_pin = 0, probe_valid = 0, reg_sel = 0, reg_wr = 0, bus_req = 0;
  logic [31:0] probe_data = 0, reg_wdata = 0, bus_addr = 0;
  logic [11:0] reg_addr = 0;
  logic probe_req, cpu_hold, sel_rom, sel_flash, remap;
  logic [31:0] probe_addr, reg_rdata, dev_addr;

  always #5 clk = ~clk;

  boot_remap_ctrl i_boot_remap_ctrl (
    .clk(clk), .rst(rst), .boot_pin(boot_pin),
    .probe_req(probe_req), .probe_addr(probe_addr),
    .probe_valid(probe_valid), .probe_data(probe_data),
    .cpu_hold(cpu_hold), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_addr(bus_addr), .sel_rom(sel_rom),
    .sel_flash(sel_flash), .dev_addr(dev_addr), .remap(remap)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // flash responder
  logic [31:0] flash_word = 0;
  int lat = 0, rcnt = 0;
  bit saw_probe = 0;
  always @(negedge clk) begin
    if (rst) begin
      probe_valid <= 0; rcnt = 0;
    end else if (probe_valid) begin
      probe_valid <= 0; rcnt = 0;
    end else if (probe_req) begin
      saw_probe = 1;
      if (rcnt >= lat) begin
        probe_valid <= 1; probe_data <= flash_word;
      end else rcnt++;
    end
  end

  // behavioural reference model
  int  m_st = 0, m_cnt = 0;
  bit  m_alias = 0, m_hold = 1, m_req = 0, m_srom = 0, m_sfl = 0, armed = 0;
  logic [31:0] m_rdata = 0, m_daddr = 0;
  always @(posedge clk) begin
    bit oa, oh;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_alias = 0; m_hold = 1; m_req = 0;
      m_rdata = 0; m_srom = 0; m_sfl = 0; m_daddr = 0; armed = 1;
    end else begin
      oa = m_alias; oh = m_hold;
      m_rdata = (reg_sel && !reg_wr && reg_addr == OFF) ? {31'b0, oa} : 32'h0;
      m_srom = 0; m_sfl = 0; m_daddr = 0;
      if (bus_req) begin
        if (bus_addr < WIN) begin
          m_srom = oa; m_sfl = !oa; m_daddr = bus_addr;
        end else if (bus_addr >= RBASE && bus_addr < RBASE + RSIZE) begin
          m_srom = 1; m_daddr = bus_addr - RBASE;
        end else if (bus_addr < FSIZE) begin
          m_sfl = 1; m_daddr = bus_addr;
        end
      end
      case (m_st)
        0: begin m_st = 1; m_cnt = 0; end
        1: if (m_cnt == SETTLE - 1) m_st = 2; else m_cnt++;
        2: if (boot_pin) begin m_alias = 1; m_hold = 0; m_st = 4; end
           else begin m_req = 1; m_st = 3; end
        3: if (probe_valid) begin
             m_alias = (probe_data == 32'hFFFF_FFFF); m_req = 0; m_hold = 0; m_st = 4;
           end
        default: ;
      endcase
      if (reg_sel && reg_wr && reg_addr == OFF && reg_wdata[0] && !oh) m_alias = 0;
    end
  end

  always @(negedge clk) begin
    if (armed && !done_flag) begin
      chk(cpu_hold === m_hold, "R1", "cpu_hold", cpu_hold, m_hold);
      chk(remap === m_alias, "R10", "remap", remap, m_alias);
      chk(probe_req === m_req, "R3", "probe_req", probe_req, m_req);
      if (m_req) chk(probe_addr === 32'h4, "R3", "probe_addr", probe_addr, 32'h4);
      chk(reg_rdata === m_rdata, "R5", "reg_rdata", reg_rdata, m_rdata);
      chk({sel_rom, sel_flash, dev_addr} === {m_srom, m_sfl, m_daddr}, "R8",
          "route", {sel_rom, sel_flash, dev_addr}, {m_srom, m_sfl, m_daddr});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done_flag) begin
      done_flag = 1;
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_boot(input bit pin, input logic [31:0] word, input int l, input bit early);
    @(negedge clk);
    rst = 1; boot_pin = pin; flash_word = word; lat = l; saw_probe = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    if (early) begin
      reg_sel = 1; reg_wr = 1; reg_addr = OFF; reg_wdata = 32'hFFFF_FFFF;
    end
    while (cpu_hold) @(negedge clk);
    reg_sel = 0; reg_wr = 0; reg_wdata = 0;
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic reg_read(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    @(negedge clk);
    reg_sel = 0;
    chk(reg_rdata === exp, req, "read", reg_rdata, exp);
  endtask

  task automatic route(input logic [31:0] a, input bit er, input bit ef,
                       input logic [31:0] ed, input string req);
    @(negedge clk);
    bus_req = 1; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    chk({sel_rom, sel_flash, dev_addr} === {er, ef, ed}, req, "decode",
        {sel_rom, sel_flash, dev_addr}, {er, ef, ed});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cpu_hold === 1 && remap === 0 && probe_req === 0 && reg_rdata === 0,
        "R1", "reset state", {cpu_hold, remap, probe_req}, 3'b100);

    // ROM requested by pin
    run_boot(1'b1, 32'h0, 2, 0);
    chk(remap === 1, "R2", "alias after ROM pin", remap, 1);
    chk(saw_probe == 0, "R2", "probe issued", saw_probe, 0);
    route(32'h0000_0010, 1, 0, 32'h10, "R8");
    route(32'h0100_0020, 1, 0, 32'h20, "R9");
    route(32'h0002_0000, 0, 1, 32'h0002_0000, "R9");
    route(32'h0005_0000, 0, 0, 32'h0, "R9");
    route(32'hFFFF_0000, 0, 0, 32'h0, "R9");
    reg_write(OFF, 32'h0);
    reg_read(OFF, 32'h1, "R6");
    reg_write(12'h0F4, 32'h1);
    reg_read(OFF, 32'h1, "R6");
    reg_read(12'h0F4, 32'h0, "R5");
    reg_write(OFF, 32'h1);
    reg_read(OFF, 32'h0, "R6");
    reg_write(OFF, 32'hFFFF_FFFF);
    reg_read(OFF, 32'h0, "R7");
    route(32'h0000_0010, 0, 1, 32'h10, "R8");
    route(32'h0100_0000, 1, 0, 32'h0, "R9");

    // blank flash with a clear-write held during the pending phase
    run_boot(1'b0, 32'hFFFF_FFFF, 5, 1);
    chk(saw_probe == 1, "R3", "probe issued", saw_probe, 1);
    chk(remap === 1, "R4", "alias on blank flash", remap, 1);
    reg_read(OFF, 32'h1, "R6");

    // one bit short of erased
    run_boot(1'b0, 32'hFFFF_FFFE, 1, 0);
    chk(remap === 0, "R4", "alias on programmed flash", remap, 0);
    reg_write(OFF, 32'h1);
    reg_read(OFF, 32'h0, "R7");
    route(32'h0000_FFFC, 0, 1, 32'hFFFC, "R8");

    // ordinary vector, zero latency
    run_boot(1'b0, 32'h0000_0201, 0, 0);
    chk(remap === 0, "R4", "alias on valid vector", remap, 0);

    // blank flash, then clear
    run_boot(1'b0, 32'hFFFF_FFFF, 3, 0);
    chk(remap === 1, "R4", "alias on blank flash", remap, 1);
    route(32'h0000_0004, 1, 0, 32'h4, "R8");
    reg_write(OFF, 32'h3);
    chk(remap === 0, "R10", "remap after clear", remap, 0);
    route(32'h0000_0004, 0, 1, 32'h4, "R8");

    repeat (3) @(negedge clk);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule